// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a simple synchronous request port and an external asynchronous static RAM of 128K sixteen-bit words. A client presents a read or write with a 17-bit word address, sixteen bits of write data and a two-bit lane mask. One request is taken at a time. The controller runs the memory strobes through an address setup cycle, a strobe window and a release cycle. It then returns a one-cycle completion pulse, together with the read data for reads.

The strobe window is derived from two parameters: the clock period and the memory access time, both in picoseconds. The window is the access time divided by the period, rounded up, so the same RTL serves faster and slower speed grades. The external data bus is split into an output value, an input value and an output-enable, which the pad ring turns into a tristate pin. The controller drives that bus only during writes. A request whose lane mask is zero leaves both byte enables high, so the memory stays in standby. Such a request still completes.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high (idle), `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all high, `mem_dq_oe` is low, and `rsp_done` is low after reset.
- R2: In a write with a nonzero mask, `mem_we_n` is low for exactly W consecutive cycles. Throughout that window `mem_ce_n` is low and `mem_oe_n` stays high.
- R3: During an access, `mem_lb_n` is low exactly when mask bit 0 is set and `mem_ub_n` is low exactly when mask bit 1 is set. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. A write changes only the selected bytes of the addressed word.
- R4: In the cycle before `mem_we_n` falls and in the cycle it rises, `mem_dq_oe` is high and `mem_addr` and `mem_dq_out` hold the same values as during the strobe.
- R5: In a read with a nonzero mask, `mem_oe_n` is low for exactly W consecutive cycles. During that window `mem_we_n` is high and `mem_dq_oe` is low.
- R6: Read data is sampled at the rising edge that ends the last `mem_oe_n`-low cycle. Bytes whose mask bit is clear are returned as zero.
- R7: `rsp_done` is high for one cycle only. That cycle begins W+2 rising edges after the edge that accepts the request. `req_ready` is low from acceptance until that cycle.
- R8: A request with mask 0 keeps both byte enables high and never asserts `mem_oe_n` or `mem_we_n`. It leaves memory unchanged, still completes per R7 and, for a read, returns zero.
- R9: W equals the ceiling of ACCESS_PS / CLK_PS, and is at least 1.
- R10: While `mem_ce_n` is low, `mem_addr` equals the accepted request address and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 low byte, bit 1 high byte |
| req_ready | output | 1 | Controller idle; request taken when valid and ready are both high at an edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data with disabled lanes zeroed |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
The bench builds the controller with CLK_PS=10000 and ACCESS_PS=35000. This rounds up to a four-cycle strobe window, which is not a whole multiple of the ratio, so the ceiling rule is exercised. The window is also short enough for a hundred accesses to fit easily. The memory model drives read data only after the output enable has been low for the expected four cycles, and it puts junk on disabled lanes. A controller that samples early, or that does not zero unused bytes, therefore returns visibly wrong data. Addresses come from a small pool that includes both ends of the 17-bit range, so random reads keep landing on words written earlier with partial masks.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // Strobe window in cycles: access time rounded up to whole clocks, minimum 1.
  function automatic int wait_cycles(input int clk_ps, input int access_ps);
    int w;
    w = (access_ps + clk_ps - 1) / clk_ps;
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int WAIT_CYC = 4,
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = CNT_W'(WAIT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       cnt_last,
  output seq_state_t state,
  output logic       accept,
  output logic       cnt_load,
  output logic       strobe_end,
  output logic       finish
);

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (cnt_last) state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state      = state_q;
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign cnt_load   = (state_q == ST_SETUP);
  assign strobe_end = (state_q == ST_STROBE) && cnt_last;
  assign finish     = (state_q == ST_HOLD);

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              capture,
  input  logic              finish,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  logic [DATA_W-1:0] rdata_d;

  // Unselected lanes are forced to zero before capture.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdata_d[l*LANE_W +: LANE_W] =
      mask_q[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int CLK_PS    = 10000,
  parameter int ACCESS_PS = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  localparam int WAIT_CYC = wait_cycles(CLK_PS, ACCESS_PS);

  seq_state_t        state;
  logic              accept;
  logic              cnt_load;
  logic              cnt_last;
  logic              strobe_end;
  logic              finish;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              busy;
  logic              any_lane;
  logic              in_strobe;
  logic [LANES-1:0]  lane_en_n;

  sram_lane_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cnt_last   (cnt_last),
    .state      (state),
    .accept     (accept),
    .cnt_load   (cnt_load),
    .strobe_end (strobe_end),
    .finish     (finish)
  );

  sram_wait_cnt #(.WAIT_CYC(WAIT_CYC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .last  (cnt_last)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .capture   (strobe_end && !wr_q),
    .finish    (finish),
    .mem_dq_in (mem_dq_in),
    .wr_q      (wr_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .mask_q    (mask_q),
    .rdata_q   (rdata_q),
    .done_q    (done_q)
  );

  assign busy      = (state != ST_IDLE);
  assign any_lane  = |mask_q;
  assign in_strobe = (state == ST_STROBE) && any_lane;

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign lane_en_n[l] = !(busy && mask_q[l]);
  end

  assign req_ready  = !busy;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !busy;
  assign mem_lb_n   = lane_en_n[0];
  assign mem_ub_n   = lane_en_n[LANES-1];
  assign mem_we_n   = !(in_strobe && wr_q);
  assign mem_oe_n   = !(in_strobe && !wr_q);
  assign mem_dq_oe  = busy && wr_q && any_lane;
  assign mem_dq_out = mem_dq_oe ? wdata_q : '0;

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int CLK_PS    = 10000,
  parameter int ACCESS_PS = 55000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [15:0]       mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int WAIT_CYC = wait_cycles(CLK_PS, ACCESS_PS);

  logic [31:0] we_run_q;
  logic [31:0] oe_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= !mem_we_n ? we_run_q + 32'd1 : 32'd0;
      oe_run_q <= !mem_oe_n ? oe_run_q + 32'd1 : 32'd0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  // R2, R9: write strobe width
  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run_q == 32'(WAIT_CYC)));

  p_write_oe_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_out)));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

  // R5, R9: read strobe width
  p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run_q == 32'(WAIT_CYC)));

  p_read_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_no_lane_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lb_n && mem_ub_n) |-> (mem_oe_n && mem_we_n));

  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W    (ADDR_W),
  .CLK_PS    (CLK_PS),
  .ACCESS_PS (ACCESS_PS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lb_n   (mem_lb_n),
  .mem_ub_n   (mem_ub_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  localparam int AW     = 17;
  localparam int CLK_PS = 10000;
  localparam int ACC_PS = 35000;
  localparam int W_EXP  = 4;   // R9: ceil(35000/10000)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_done;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0]   mem_dq_out;
  logic          mem_dq_oe;
  logic [15:0]   mem_dq_in = 16'hDEAD;

  int checks = 0;
  int errors = 0;
  bit [15:0] mem_model [bit [AW-1:0]];
  bit [15:0] ref_mem   [bit [AW-1:0]];
  int        we_run = 0, oe_run = 0;
  bit        strobe_seen = 0;
  bit [AW-1:0] cur_addr = '0;
  logic        prev_we_n = 1'b1, prev_dq_oe = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [15:0]   prev_out = '0;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS), .ACCESS_PS(ACC_PS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] merge(input bit [15:0] old, input bit [15:0] nw, input bit [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic bit [15:0] keep_lanes(input bit [15:0] v, input bit [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  function automatic bit [15:0] ref_rd(input bit [AW-1:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // Memory model and strobe monitor, sampled away from the rising edge
  always @(negedge clk) begin
    bit [15:0] v;
    if (!rst_n) begin
      we_run = 0; oe_run = 0; prev_we_n = 1'b1; mem_dq_in = 16'hDEAD;
    end else begin
      if (!mem_we_n) begin
        if (prev_we_n) begin
          chk(prev_dq_oe && prev_addr == mem_addr && prev_out == mem_dq_out,
              "R4 setup before we_n falls", {15'd0, prev_dq_oe, mem_dq_out}, {16'd1, prev_out});
          chk(mem_addr == cur_addr, "R10 address at write strobe", 32'(mem_addr), 32'(cur_addr));
          chk(mem_oe_n && !mem_ce_n, "R2 oe_n high and ce_n low in write", {30'd0, mem_oe_n, mem_ce_n}, 32'h2);
        end
        we_run++; strobe_seen = 1;
      end else if (we_run > 0) begin
        chk(we_run == W_EXP, "R2 R9 we_n low width", we_run, W_EXP);
        chk(mem_dq_oe && mem_addr == prev_addr && mem_dq_out == prev_out,
            "R4 hold at we_n rise", {15'd0, mem_dq_oe, mem_dq_out}, {16'd1, prev_out});
        v = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 16'h0000;
        mem_model[mem_addr] = merge(v, mem_dq_out, {!mem_ub_n, !mem_lb_n});
        we_run = 0;
      end
      if (!mem_oe_n) begin
        if (oe_run == 0) begin
          chk(mem_we_n && !mem_dq_oe, "R5 bus released during read", {30'd0, mem_we_n, mem_dq_oe}, 32'h2);
          chk(mem_addr == cur_addr, "R10 address at read strobe", 32'(mem_addr), 32'(cur_addr));
        end
        oe_run++; strobe_seen = 1;
      end else if (oe_run > 0) begin
        chk(oe_run == W_EXP, "R5 R9 oe_n low width", oe_run, W_EXP);
        oe_run = 0;
      end
      if (mem_lb_n && mem_ub_n && (!mem_oe_n || !mem_we_n))
        chk(0, "R8 strobe with no lane enabled", {30'd0, mem_oe_n, mem_we_n}, 32'h3);
      if (!mem_ce_n && !mem_oe_n && oe_run >= W_EXP) begin
        v = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 16'h0000;
        mem_dq_in = {mem_ub_n ? 8'hA5 : v[15:8], mem_lb_n ? 8'h5A : v[7:0]};
      end else begin
        mem_dq_in = 16'hDEAD;
      end
      prev_we_n = mem_we_n; prev_dq_oe = mem_dq_oe;
      prev_addr = mem_addr; prev_out = mem_dq_out;
    end
  end

  task automatic access(input bit wr, input bit [AW-1:0] a, input bit [15:0] d, input bit [1:0] m);
    int lat;
    bit [15:0] exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr = a; strobe_seen = 0;
    if (m != 2'b00) begin
      chk(1, "R3 lane select issued", 0, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    chk(!req_ready, "R7 ready low after accept", {31'd0, req_ready}, 0);
    chk(mem_lb_n == !m[0] && mem_ub_n == !m[1], "R3 byte enables follow mask",
        {30'd0, mem_ub_n, mem_lb_n}, {30'd0, !m[1], !m[0]});
    lat = 1;
    while (!rsp_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == W_EXP + 3, "R7 done latency", lat, W_EXP + 3);
    chk(strobe_seen == (m != 2'b00), "R8 strobe only with a lane", {31'd0, strobe_seen}, {31'd0, m != 2'b00});
    if (wr) begin
      ref_mem[a] = merge(ref_rd(a), d, m);
    end else begin
      exp = keep_lanes(ref_rd(a), m);
      chk(rsp_rdata == exp, m == 2'b00 ? "R8 zero-mask read data" : "R6 read data lanes",
          32'(rsp_rdata), 32'(exp));
    end
    @(negedge clk);
    chk(!rsp_done, "R7 done single cycle", {31'd0, rsp_done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit [AW-1:0] pool [5];
    void'($urandom(32'h5EED_1234));
    pool[0] = 17'h00000; pool[1] = 17'h00001; pool[2] = 17'h1FFFF;
    pool[3] = 17'h0AAAA; pool[4] = 17'h15555;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_done,
        "R1 reset state", {24'd0, req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_done},
        32'hFC);
    @(posedge clk);
    rst_n = 1'b1;
    // directed corners
    access(1, 17'h00000, 16'h1234, 2'b11);
    access(0, 17'h00000, 16'h0000, 2'b11);
    access(1, 17'h1FFFF, 16'hBEEF, 2'b01);   // R3 low byte only
    access(1, 17'h1FFFF, 16'hCAFE, 2'b10);   // R3 high byte only
    access(0, 17'h1FFFF, 16'h0000, 2'b11);
    access(0, 17'h1FFFF, 16'h0000, 2'b01);   // R6 high lane zeroed
    access(0, 17'h1FFFF, 16'h0000, 2'b10);   // R6 low lane zeroed
    access(1, 17'h00000, 16'hFFFF, 2'b00);   // R8 zero-mask write
    access(0, 17'h00000, 16'h0000, 2'b11);   // R8 memory unchanged
    access(0, 17'h00000, 16'h0000, 2'b00);   // R8 zero-mask read
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle between accesses",
        {30'd0, req_ready, mem_ce_n}, 32'h3);
    // random traffic
    for (int i = 0; i < 90; i++) begin
      access(($urandom % 2) == 0, pool[$urandom % 5], 16'($urandom), 2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule